// File: doc/BRIEF.md
# Memory-Mapped Parallel Port Bank with Edge Flags

This block gives a processor several 8-bit bidirectional ports that it reaches with ordinary loads and stores at small offsets from an I/O base. Each pin is open-collector style: it is pulled low only while its output bit holds 0. Otherwise it is released to its pull-up, so software can read back the level that the outside world forces. Reads return pin levels after a two-stage synchroniser.

Two pins of port 0 each carry an edge latch. Pin 0 captures rising edges and pin 1 captures falling edges. A flag stays set until software touches its clear offset, either by reading or by writing. These offsets hold no data. A control register holds two enable bits that gate the flags onto two interrupt request outputs. Both flags can be read at the same address.

Top module: `mmio_port_bank`

## Requirements
- R1: Offsets 0x0 to 0x3 select ports 0 to 3. A write stores the port's output register. A read returns that port's synchronised pin levels, which reflect a pin change after two rising clock edges.
- R2: `pin_drive_low` bit 8k+i is 1 exactly when bit i of port k's output register is 0.
- R3: Reset sets every output register to all ones, so no pin is driven low. It also clears both enable bits and both edge flags, and both interrupt requests are low.
- R4: A rising edge on `pin_in[0]` sets the rise flag, which reads as bit 7 of the control register at offset 0xF. It is visible after the third rising clock edge that follows the pin change.
- R5: A falling edge on `pin_in[1]` sets the fall flag, which reads as bit 6 of the control register, with the same latency as R4.
- R6: Any bus access (read or write) to offset 0x9 clears the rise flag, and one to offset 0xA clears the fall flag. Writes there change no port and no enable bit. If an edge and its clear fall in the same cycle, the flag ends set.
- R7: Control register bits 0 (rise enable) and 1 (fall enable) are writable and read back. Bits 2 to 5 read as 0.
- R8: `irq_rise` is the rise flag ANDed with enable bit 0, and `irq_fall` is the fall flag ANDed with enable bit 1. Both are combinational from the registers.
- R9: Offsets 0x4 to 0x8 and 0xB to 0xE read as 0, and writes to them have no effect.
- R10: A falling edge on `pin_in[0]` and a rising edge on `pin_in[1]` set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Offset from the I/O base |
| bus_wdata | input | WIDTH (8) | Write data |
| bus_rdata | output | WIDTH (8) | Read data, combinational from the address |
| pin_in | input | PORTS*WIDTH (32) | Sampled pin levels, port k in bits 8k+7..8k |
| pin_drive_low | output | PORTS*WIDTH (32) | 1 pulls the pin low, 0 releases it |
| irq_rise | output | 1 | Rising-edge interrupt request on port 0 pin 0 |
| irq_fall | output | 1 | Falling-edge interrupt request on port 0 pin 1 |

## Verification
Writes to output registers and to the enable bits take effect at the clock edge that captures the access. Readback follows a pin change after two edges, and an edge flag is set at the third edge. The interrupt lines follow the flag and enable registers in the same cycle. The bench drives stimulus on falling clock edges and counts rising edges to the exact cycle each result is due. It samples one cycle early for the readback and flag latencies to show the value has not yet moved. To exercise the same-cycle rule, it places a clear access on the edge that would set a flag.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
   localparam int OFF_CLR_RISE   = 9;
   localparam int OFF_CLR_FALL   = 10;
   localparam int OFF_CTRL       = 15;
   localparam int CTRL_EN_RISE   = 0;
   localparam int CTRL_EN_FALL   = 1;
   localparam int CTRL_FLAG_FALL = 6;
   localparam int CTRL_FLAG_RISE = 7;
   localparam int RISE_PIN       = 0;
   localparam int FALL_PIN       = 1;
endpackage

// File: rtl/io_sync.sv
module io_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] st;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[i] <= '1;
            else        st[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[i] <= '1;
            else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/edge_latch.sv
module edge_latch #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic clr,
   output logic pulse,
   output logic flag
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= level;

   if (RISING) begin : g_rise
      assign pulse = level & ~prev;
   end else begin : g_fall
      assign pulse = ~level & prev;
   end

   // a detected edge outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)     flag <= 1'b0;
      else if (pulse) flag <= 1'b1;
      else if (clr)   flag <= 1'b0;
endmodule

// File: rtl/mmio_port_bank.sv
module mmio_port_bank
   import mpb_pkg::*;
#(
   parameter int PORTS       = 4,
   parameter int WIDTH       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [WIDTH-1:0]       bus_wdata,
   output logic [WIDTH-1:0]       bus_rdata,
   input  logic [PORTS*WIDTH-1:0] pin_in,
   output logic [PORTS*WIDTH-1:0] pin_drive_low,
   output logic                   irq_rise,
   output logic                   irq_fall
);
   localparam int NPINS = PORTS * WIDTH;

   initial begin : elab_checks
      assert (PORTS >= 1 && PORTS <= OFF_CLR_RISE)
         else $error("PORTS must lie in 1..%0d", OFF_CLR_RISE);
      assert (WIDTH >= CTRL_FLAG_RISE + 1) else $error("WIDTH too small for control layout");
      assert (ADDR_W >= 4) else $error("ADDR_W must reach offset 0xF");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [PORTS-1:0][WIDTH-1:0] port_q;
   logic [NPINS-1:0]            pin_sync;
   logic [1:0]                  ctrl_en;
   logic rise_pulse, fall_pulse, rise_flag, fall_flag;
   logic hit_clr_rise, hit_clr_fall, wr_ctrl;

   assign hit_clr_rise = bus_sel && (bus_addr == ADDR_W'(OFF_CLR_RISE));
   assign hit_clr_fall = bus_sel && (bus_addr == ADDR_W'(OFF_CLR_FALL));
   assign wr_ctrl      = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) port_q[p] <= '1;
         else if (bus_sel && bus_wr && bus_addr == ADDR_W'(p)) port_q[p] <= bus_wdata;
   end

   assign pin_drive_low = ~port_q;

   io_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   edge_latch #(.RISING(1'b1)) u_rise (
      .clk(clk), .rst_n(rst_n), .level(pin_sync[RISE_PIN]), .clr(hit_clr_rise),
      .pulse(rise_pulse), .flag(rise_flag)
   );

   edge_latch #(.RISING(1'b0)) u_fall (
      .clk(clk), .rst_n(rst_n), .level(pin_sync[FALL_PIN]), .clr(hit_clr_fall),
      .pulse(fall_pulse), .flag(fall_flag)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ctrl_en <= 2'b00;
      else if (wr_ctrl) ctrl_en <= {bus_wdata[CTRL_EN_FALL], bus_wdata[CTRL_EN_RISE]};

   assign irq_rise = rise_flag & ctrl_en[0];
   assign irq_fall = fall_flag & ctrl_en[1];

   always_comb begin
      bus_rdata = '0;
      for (int p = 0; p < PORTS; p++)
         if (bus_addr == ADDR_W'(p)) bus_rdata = pin_sync[p*WIDTH +: WIDTH];
      if (bus_addr == ADDR_W'(OFF_CTRL)) begin
         bus_rdata[CTRL_EN_RISE]   = ctrl_en[0];
         bus_rdata[CTRL_EN_FALL]   = ctrl_en[1];
         bus_rdata[CTRL_FLAG_FALL] = fall_flag;
         bus_rdata[CTRL_FLAG_RISE] = rise_flag;
      end
   end
endmodule

// File: rtl/mpb_checker.sv
module mpb_checker
   import mpb_pkg::*;
#(
   parameter int PORTS  = 4,
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_sel,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [WIDTH-1:0]       bus_wdata,
   input logic [PORTS*WIDTH-1:0] pin_drive_low,
   input logic                   irq_rise,
   input logic                   irq_fall,
   input logic                   rise_pulse,
   input logic                   fall_pulse,
   input logic [1:0]             ctrl_en
);
   p_port0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == '0) |=> pin_drive_low[WIDTH-1:0] == ~$past(bus_wdata));

   p_hold_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> $stable(pin_drive_low));

   p_clear_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr == ADDR_W'(OFF_CLR_RISE) && !rise_pulse) |=> !irq_rise);

   p_clear_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_addr == ADDR_W'(OFF_CLR_FALL) && !fall_pulse) |=> !irq_fall);

   p_edge_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_pulse && ctrl_en[0] && !(bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CTRL)))
      |=> irq_rise);

   p_fall_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_pulse && ctrl_en[1] && !(bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CTRL)))
      |=> irq_fall);

   p_disable_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_CTRL) && !bus_wdata[CTRL_EN_RISE])
      |=> !irq_rise);

   p_flag_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise_pulse && !bus_sel) |=> $stable(irq_rise));
endmodule

bind mmio_port_bank mpb_checker #(.PORTS(PORTS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mmio_port_bank_bench.sv
`timescale 1ns/1ps
module mmio_port_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [31:0] pin_in = '1;
   logic [31:0] pin_drive_low;
   logic        irq_rise, irq_fall;

   int errors = 0, checks = 0;
   logic [7:0] exp_out [4];
   logic [7:0] rd_val;

   always #2.5 clk = ~clk;

   mmio_port_bank u_mmio_port_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_drive_low(pin_drive_low), .irq_rise(irq_rise), .irq_fall(irq_fall)
   );

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_drive();
      return ~{exp_out[3], exp_out[2], exp_out[1], exp_out[0]};
   endfunction

   // entered and left on a falling edge
   task automatic bus_write(logic [3:0] a, logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(logic [3:0] a, output logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C};
      for (int p = 0; p < 4; p++) exp_out[p] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 reset state
      check("R3 drive_low", pin_drive_low, 32'h0);
      check("R3 irq", {irq_rise, irq_fall}, 0);
      bus_read(4'hF, rd_val);
      check("R3 ctrl", rd_val, 8'h00);

      // R1 R2 output register sweep
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 5; k++) begin
            logic [7:0] v;
            v = pats[k] ^ 8'(p * 17);
            bus_write(4'(p), v);
            exp_out[p] = v;
            check("R2 drive_low", pin_drive_low, exp_drive());
         end

      // R1 readback sweep
      for (int p = 0; p < 4; p++)
         for (int k = 0; k < 5; k++) begin
            logic [7:0] v;
            v = pats[k] + 8'(p);
            pin_in[p*8 +: 8] = v;
            edges(2);
            bus_read(4'(p), rd_val);
            check("R1 readback", rd_val, v);
         end

      // R1 readback latency: not visible after one edge
      pin_in[15:8] = 8'hC3;
      edges(2);
      pin_in[15:8] = 8'h81;
      edges(1);
      bus_read(4'h1, rd_val);
      check("R1 readback early", rd_val, 8'hC3);
      edges(1);
      bus_read(4'h1, rd_val);
      check("R1 readback due", rd_val, 8'h81);

      // settle pins and clear both flags
      pin_in[1:0] = 2'b11;
      edges(4);
      bus_read(4'h9, rd_val);
      bus_read(4'hA, rd_val);
      bus_read(4'hF, rd_val);
      check("R6 flags cleared", rd_val, 8'h00);

      // R9 unmapped offsets
      for (int a = 4; a < 15; a++) begin
         if (a == 9 || a == 10) continue;
         bus_write(4'(a), 8'h00);
         bus_read(4'(a), rd_val);
         check("R9 unmapped read", rd_val, 8'h00);
      end
      check("R9 ports untouched", pin_drive_low, exp_drive());
      bus_read(4'hF, rd_val);
      check("R9 ctrl untouched", rd_val, 8'h00);

      // R7 control bits
      bus_write(4'hF, 8'hFF);
      bus_read(4'hF, rd_val);
      check("R7 ctrl readback", rd_val, 8'h03);
      bus_write(4'hF, 8'h00);
      bus_read(4'hF, rd_val);
      check("R7 ctrl cleared", rd_val, 8'h00);

      // R4 rising edge on pin 0 and its latency
      pin_in[0] = 1'b0;
      edges(4);
      bus_read(4'h9, rd_val);
      pin_in[0] = 1'b1;
      edges(2);
      bus_read(4'hF, rd_val);
      check("R4 flag not yet", rd_val[7], 1'b0);
      bus_read(4'hF, rd_val);
      check("R4 flag set", rd_val, 8'h80);
      check("R8 irq_rise masked", irq_rise, 1'b0);
      bus_write(4'hF, 8'h01);
      check("R8 irq_rise enabled", irq_rise, 1'b1);
      check("R8 irq_fall idle", irq_fall, 1'b0);
      bus_read(4'h9, rd_val);
      check("R6 read clears rise", irq_rise, 1'b0);
      bus_read(4'hF, rd_val);
      check("R6 rise flag gone", rd_val, 8'h01);

      // R10 opposite edges ignored
      pin_in[0] = 1'b0;
      edges(4);
      bus_read(4'hF, rd_val);
      check("R10 falling on pin0", rd_val, 8'h01);
      pin_in[1] = 1'b0;
      edges(4);
      bus_read(4'hA, rd_val);
      pin_in[1] = 1'b1;
      edges(4);
      bus_read(4'hF, rd_val);
      check("R10 rising on pin1", rd_val, 8'h01);

      // R5 falling edge on pin 1
      pin_in[1] = 1'b0;
      edges(3);
      bus_read(4'hF, rd_val);
      check("R5 fall flag", rd_val, 8'h41);
      check("R8 irq_fall masked", irq_fall, 1'b0);
      bus_write(4'hF, 8'h02);
      check("R8 irq_fall enabled", {irq_rise, irq_fall}, 2'b01);
      bus_write(4'hA, 8'hFF);
      check("R6 write clears fall", irq_fall, 1'b0);
      check("R6 write stores nothing", pin_drive_low, exp_drive());
      bus_read(4'hF, rd_val);
      check("R6 enables kept", rd_val, 8'h02);

      // R6 edge and clear in the same cycle: flag ends set
      pin_in[0] = 1'b0;
      edges(4);
      bus_read(4'h9, rd_val);
      pin_in[0] = 1'b1;
      edges(2);
      bus_read(4'h9, rd_val);
      bus_read(4'hF, rd_val);
      check("R6 set wins", rd_val[7], 1'b1);
      bus_read(4'h9, rd_val);
      bus_read(4'hF, rd_val);
      check("R6 later clear", rd_val[7], 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule